// File: doc/BRIEF.md
# Split-Link Shunt Current Reference Generator

This block computes the reference currents for a shunt active filter whose converter has a DC link split across two capacitors. Each accepted sample carries three load currents, three unit-amplitude synchronising sines from a phase-locked loop, and the two capacitor voltages, all as signed fixed-point words. From these it forms an instantaneous equivalent conductance. It smooths that conductance over a window of recent samples, and a separate proportional-integral regulator for each capacitor adds its own correction. The result is two sets of ideal sinusoidal currents, and each reference is the difference between an ideal current and the load current of the same phase.

Samples enter on a valid/ready stream and results leave on a second valid/ready stream. Only one sample is processed at a time. `in_ready` is high only while the block is idle. Once the six references are presented, they stay frozen until the consumer raises `out_ready`, and no new sample is taken before that. The total DC setpoint is a plain control input, and each capacitor is regulated to half of it.

Top module: `shunt_ref_gen`

## Requirements
- R1: `in_ready` is high exactly when no sample is being processed and no result is waiting. A sample is taken on a rising clock edge where `in_valid` and `in_ready` are both high.
- R2: `out_valid` rises exactly LAT = 2*DW+FB+3 clock edges after the accepting edge (47 with default parameters).
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and all six references hold their values. The edge where both are high ends the transfer, so `out_valid` is low after it.
- R4: The conductance is G = (sa*ia + sb*ib + sc*ic) * 2^FB / (sa^2 + sb^2 + sc^2). The division truncates toward zero, and the magnitude is limited to 2^(DW-1)-1. G carries FB fractional bits.
- R5: When the three synchronising inputs are all zero, the denominator is zero and the previous G is used again. The value after reset is 0.
- R6: Gbar is the sum of the last 2^WIN_LOG2 values of G, shifted arithmetically right by WIN_LOG2 (floor). Window slots read as zero after reset.
- R7: For capacitor k, the error is e = (vlink_ref >>> 1) - vcap_k. The integrator becomes I = clamp(I + KI*e) and the correction is Gl_k = sat((KP*e + I) >>> PI_SH), using the updated integrator.
- R8: Ge_k = sat(Gbar + Gl_k). The reference for set k and phase x is sat(((Ge_k * s_x) >>> FB) - i_x). Here sat limits the value to the signed DW-bit range, set 1 drives `iref1_*` and set 2 drives `iref2_*`.
- R9: The two sets differ only through their own capacitor voltage. After reset, if vcap_1 equals vcap_2 in every sample, the two reference sets are equal.
- R10: After reset, `out_valid` is 0, `in_ready` is 1 and all references are 0.
- R11: The integrator is clamped to [-ILIM, +ILIM]. With default parameters, vlink_ref = 0 and vcap = -32768 held long enough, Gl settles at 18432.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can accept a sample |
| sync_a | input | DW | Unit sine in phase with phase a, signed, FB fraction bits |
| sync_b | input | DW | Unit sine for phase b |
| sync_c | input | DW | Unit sine for phase c |
| iload_a | input | DW | Load current phase a, signed |
| iload_b | input | DW | Load current phase b, signed |
| iload_c | input | DW | Load current phase c, signed |
| vcap_1 | input | DW | Voltage on capacitor 1, signed |
| vcap_2 | input | DW | Voltage on capacitor 2, signed |
| vlink_ref | input | DW | Total DC-link setpoint, signed, plain control input |
| out_valid | output | 1 | References valid |
| out_ready | input | 1 | Consumer accepts the references |
| iref1_a | output | DW | Reference, set 1, phase a |
| iref1_b | output | DW | Reference, set 1, phase b |
| iref1_c | output | DW | Reference, set 1, phase c |
| iref2_a | output | DW | Reference, set 2, phase a |
| iref2_b | output | DW | Reference, set 2, phase b |
| iref2_c | output | DW | Reference, set 2, phase c |

## Verification
The integrator limit is the hardest case to reach from the ports. The stimulus gets there by holding the setpoint at zero and both capacitor voltages at the most negative code for 40 samples, with only one synchronising input non-zero and no load current, so that G and Gbar stay zero and the settled correction appears directly on the phase-a references. The held-conductance path is reached by sending a sample whose synchronising inputs are all zero between normal samples, and its effect is seen in the window average of the following samples. Random streams with random output stalls cover the arithmetic and the back-pressure rules.

// File: rtl/srg_pkg.sv
package srg_pkg;
  localparam int NPH  = 3;
  localparam int NSET = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOAD,
    ST_DIV,
    ST_AVG,
    ST_FIN,
    ST_OUT
  } srg_state_e;
endpackage

// File: rtl/srg_divider.sv
module srg_divider #(
  parameter int NW = 44,
  parameter int VW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [VW-1:0] divisor,
  output logic [NW-1:0] quotient,
  output logic          last
);
  localparam int CW = $clog2(NW + 1);

  logic [CW-1:0] cnt;
  logic [VW-1:0] rem;
  logic [VW-1:0] dvs;
  logic [VW:0]   trial;

  assign trial = {rem, quotient[NW-1]};
  assign last  = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quotient <= '0;
      rem      <= '0;
      dvs      <= '0;
      cnt      <= '0;
    end else if (start) begin
      quotient <= dividend;
      rem      <= '0;
      dvs      <= divisor;
      cnt      <= CW'(NW);
    end else if (cnt != '0) begin
      if (trial >= {1'b0, dvs}) begin
        rem      <= VW'(trial - {1'b0, dvs});
        quotient <= {quotient[NW-2:0], 1'b1};
      end else begin
        rem      <= trial[VW-1:0];
        quotient <= {quotient[NW-2:0], 1'b0};
      end
      cnt <= cnt - CW'(1);
    end
  end
endmodule

// File: rtl/srg_mavg.sv
module srg_mavg #(
  parameter int DW = 16,
  parameter int WL = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] g_in,
  output logic signed [DW-1:0] avg
);
  localparam int DEPTH = 1 << WL;
  localparam int SUMW  = DW + WL;

  logic signed [DW-1:0]   slot_q [DEPTH];
  logic [WL-1:0]          wptr;
  logic signed [SUMW-1:0] sum_q;
  logic signed [SUMW-1:0] shr;

  assign shr = sum_q >>> WL;
  assign avg = shr[DW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
      wptr  <= '0;
      sum_q <= '0;
    end else if (upd) begin
      slot_q[wptr] <= g_in;
      sum_q        <= sum_q + SUMW'(g_in) - SUMW'(slot_q[wptr]);
      wptr         <= wptr + WL'(1);
    end
  end
endmodule

// File: rtl/srg_pi.sv
module srg_pi #(
  parameter int DW   = 16,
  parameter int IW   = 32,
  parameter int KP   = 4,
  parameter int KI   = 1,
  parameter int SH   = 6,
  parameter int ILIM = 1048576
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 upd,
  input  logic signed [DW-1:0] vset,
  input  logic signed [DW-1:0] vdc,
  output logic signed [DW-1:0] gl
);
  localparam logic signed [IW-1:0] LIM  = IW'(ILIM);
  localparam logic signed [IW-1:0] GMAX = IW'((1 << (DW - 1)) - 1);
  localparam logic signed [IW-1:0] GMIN = -IW'(1 << (DW - 1));

  logic signed [IW-1:0] integ_q;
  logic signed [IW-1:0] err;
  logic signed [IW-1:0] acc;
  logic signed [IW-1:0] integ_n;
  logic signed [IW-1:0] shifted;

  always_comb begin
    err = IW'(vset) - IW'(vdc);
    acc = integ_q + err * IW'(KI);
    if (acc > LIM)       integ_n = LIM;
    else if (acc < -LIM) integ_n = -LIM;
    else                 integ_n = acc;
    shifted = (err * IW'(KP) + integ_n) >>> SH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      gl      <= '0;
    end else if (upd) begin
      integ_q <= integ_n;
      if (shifted > GMAX)      gl <= GMAX[DW-1:0];
      else if (shifted < GMIN) gl <= GMIN[DW-1:0];
      else                     gl <= shifted[DW-1:0];
    end
  end
endmodule

// File: rtl/srg_synth.sv
module srg_synth #(
  parameter int DW  = 16,
  parameter int FB  = 12,
  parameter int NPH = 3
) (
  input  logic signed [DW-1:0] gbar,
  input  logic signed [DW-1:0] gl,
  input  logic signed [DW-1:0] sync_v [NPH],
  input  logic signed [DW-1:0] iload_v [NPH],
  output logic signed [DW-1:0] iref_v [NPH]
);
  localparam int PW = 2 * DW + 2;
  localparam logic signed [PW-1:0] OMAX = PW'((1 << (DW - 1)) - 1);
  localparam logic signed [PW-1:0] OMIN = -PW'(1 << (DW - 1));

  logic signed [PW-1:0] ge_w;
  logic signed [DW-1:0] ge;

  always_comb begin
    ge_w = PW'(gbar) + PW'(gl);
    if (ge_w > OMAX)      ge = OMAX[DW-1:0];
    else if (ge_w < OMIN) ge = OMIN[DW-1:0];
    else                  ge = ge_w[DW-1:0];
  end

  for (genvar x = 0; x < NPH; x++) begin : g_phase
    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] diff;
    always_comb begin
      prod = PW'(ge) * PW'(sync_v[x]);
      diff = (prod >>> FB) - PW'(iload_v[x]);
      if (diff > OMAX)      iref_v[x] = OMAX[DW-1:0];
      else if (diff < OMIN) iref_v[x] = OMIN[DW-1:0];
      else                  iref_v[x] = diff[DW-1:0];
    end
  end
endmodule

// File: rtl/shunt_ref_gen.sv
module shunt_ref_gen
  import srg_pkg::*;
#(
  parameter int DW       = 16,
  parameter int FB       = 12,
  parameter int WIN_LOG2 = 4,
  parameter int KP       = 4,
  parameter int KI       = 1,
  parameter int PI_SH    = 6,
  parameter int IW       = 32,
  parameter int ILIM     = 1048576
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] sync_a,
  input  logic signed [DW-1:0] sync_b,
  input  logic signed [DW-1:0] sync_c,
  input  logic signed [DW-1:0] iload_a,
  input  logic signed [DW-1:0] iload_b,
  input  logic signed [DW-1:0] iload_c,
  input  logic signed [DW-1:0] vcap_1,
  input  logic signed [DW-1:0] vcap_2,
  input  logic signed [DW-1:0] vlink_ref,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic signed [DW-1:0] iref1_a,
  output logic signed [DW-1:0] iref1_b,
  output logic signed [DW-1:0] iref1_c,
  output logic signed [DW-1:0] iref2_a,
  output logic signed [DW-1:0] iref2_b,
  output logic signed [DW-1:0] iref2_c
);
  localparam int PW   = 2 * DW;
  localparam int SW   = PW + 2;
  localparam int DENW = PW;
  localparam int DVW  = PW + FB;
  localparam int LAT  = DVW + 3;
  localparam logic [DW-1:0] GLIM = DW'((1 << (DW - 1)) - 1);

  srg_state_e state;

  logic signed [DW-1:0] sync_q  [NPH];
  logic signed [DW-1:0] iload_q [NPH];
  logic signed [DW-1:0] vcap_q  [NSET];
  logic signed [DW-1:0] vset_q;
  logic signed [DW-1:0] gl      [NSET];
  logic signed [DW-1:0] ref_c   [NSET][NPH];
  logic signed [DW-1:0] ref_q   [NSET][NPH];

  logic signed [SW-1:0] num_c;
  logic [DENW-1:0]      den_c;
  logic [SW-1:0]        mag_c;
  logic [DVW-1:0]       quo;
  logic                 div_last;
  logic                 neg_q;
  logic                 dz_q;
  logic signed [DW-1:0] g_q;
  logic signed [DW-1:0] g_new;
  logic [DW-1:0]        gmag;
  logic signed [DW-1:0] gbar;

  assign in_ready = (state == ST_IDLE);

  // Numerator and denominator of the conductance, from the captured sample.
  always_comb begin
    num_c = '0;
    den_c = '0;
    for (int i = 0; i < NPH; i++) begin
      num_c = num_c + SW'(sync_q[i]) * SW'(iload_q[i]);
      den_c = den_c + DENW'(SW'(sync_q[i]) * SW'(sync_q[i]));
    end
    mag_c = num_c[SW-1] ? SW'(-num_c) : SW'(num_c);
  end

  srg_divider #(.NW(DVW), .VW(DENW)) div_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (state == ST_LOAD),
    .dividend ({mag_c[DENW-1:0], {FB{1'b0}}}),
    .divisor  (den_c),
    .quotient (quo),
    .last     (div_last)
  );

  // Saturated signed conductance, or the held value when the divisor was zero.
  always_comb begin
    if (|quo[DVW-1:DW-1]) gmag = GLIM;
    else                  gmag = {1'b0, quo[DW-2:0]};
    if (dz_q)       g_new = g_q;
    else if (neg_q) g_new = -$signed(gmag);
    else            g_new = $signed(gmag);
  end

  srg_mavg #(.DW(DW), .WL(WIN_LOG2)) avg_i (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (state == ST_AVG),
    .g_in  (g_new),
    .avg   (gbar)
  );

  for (genvar k = 0; k < NSET; k++) begin : g_set
    srg_pi #(
      .DW(DW), .IW(IW), .KP(KP), .KI(KI), .SH(PI_SH), .ILIM(ILIM)
    ) pi_i (
      .clk   (clk),
      .rst_n (rst_n),
      .upd   (state == ST_LOAD),
      .vset  (vset_q),
      .vdc   (vcap_q[k]),
      .gl    (gl[k])
    );

    srg_synth #(.DW(DW), .FB(FB), .NPH(NPH)) syn_i (
      .gbar    (gbar),
      .gl      (gl[k]),
      .sync_v  (sync_q),
      .iload_v (iload_q),
      .iref_v  (ref_c[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      out_valid <= 1'b0;
      neg_q     <= 1'b0;
      dz_q      <= 1'b0;
      g_q       <= '0;
      vset_q    <= '0;
      for (int i = 0; i < NPH; i++) begin
        sync_q[i]  <= '0;
        iload_q[i] <= '0;
      end
      for (int k = 0; k < NSET; k++) begin
        vcap_q[k] <= '0;
        for (int i = 0; i < NPH; i++) ref_q[k][i] <= '0;
      end
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          sync_q[0]  <= sync_a;
          sync_q[1]  <= sync_b;
          sync_q[2]  <= sync_c;
          iload_q[0] <= iload_a;
          iload_q[1] <= iload_b;
          iload_q[2] <= iload_c;
          vcap_q[0]  <= vcap_1;
          vcap_q[1]  <= vcap_2;
          vset_q     <= vlink_ref >>> 1;
          state      <= ST_LOAD;
        end
        ST_LOAD: begin
          neg_q <= num_c[SW-1];
          dz_q  <= (den_c == '0);
          state <= ST_DIV;
        end
        ST_DIV: if (div_last) state <= ST_AVG;
        ST_AVG: begin
          g_q   <= g_new;
          state <= ST_FIN;
        end
        ST_FIN: begin
          for (int k = 0; k < NSET; k++)
            for (int i = 0; i < NPH; i++) ref_q[k][i] <= ref_c[k][i];
          out_valid <= 1'b1;
          state     <= ST_OUT;
        end
        ST_OUT: if (out_ready) begin
          out_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign iref1_a = ref_q[0][0];
  assign iref1_b = ref_q[0][1];
  assign iref1_c = ref_q[0][2];
  assign iref2_a = ref_q[1][0];
  assign iref2_b = ref_q[1][1];
  assign iref2_c = ref_q[1][2];
endmodule

// File: rtl/srg_checker.sv
module srg_checker #(
  parameter int DW  = 16,
  parameter int LAT = 47
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 out_ready,
  input logic signed [DW-1:0] iref1_a,
  input logic signed [DW-1:0] iref1_b,
  input logic signed [DW-1:0] iref1_c,
  input logic signed [DW-1:0] iref2_a,
  input logic signed [DW-1:0] iref2_b,
  input logic signed [DW-1:0] iref2_c
);
  logic        busy;
  logic [15:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      lat_cnt <= '0;
    end else begin
      if (in_valid && in_ready) begin
        busy    <= 1'b1;
        lat_cnt <= '0;
      end else if (busy && !out_valid) begin
        lat_cnt <= lat_cnt + 16'd1;
      end
      if (out_valid && out_ready) busy <= 1'b0;
    end
  end

  // R1: no new sample while a result waits
  a_r1_ready_excl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R1: a taken sample keeps the input closed until its result is handed over
  a_r1_busy_closed: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !in_ready);

  // R2: fixed latency from accept to valid
  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == 16'(LAT)));

  // R3: held result under back-pressure
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(iref1_a) && $stable(iref1_b)
      && $stable(iref1_c) && $stable(iref2_a) && $stable(iref2_b) && $stable(iref2_c)));

  // R3: handshake completes the transfer
  a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);
endmodule

bind shunt_ref_gen srg_checker #(.DW(DW), .LAT(LAT)) chk_i (.*);

// File: tb/shunt_ref_gen_tb_top.sv
module shunt_ref_gen_tb_top;
  localparam int DW = 16, FB = 12, WL = 4, KP = 4, KI = 1, SH = 6;
  localparam longint ILIM = 1048576;
  localparam int LAT = 2 * DW + FB + 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_ready;
  logic signed [DW-1:0] sync_a, sync_b, sync_c, iload_a, iload_b, iload_c;
  logic signed [DW-1:0] vcap_1, vcap_2, vlink_ref;
  logic signed [DW-1:0] iref1_a, iref1_b, iref1_c, iref2_a, iref2_b, iref2_c;

  shunt_ref_gen dut_i (.*);

  int total = 0, bad = 0;
  longint cyc_all = 0;

  // stimulus and model state
  longint s_sync[3], s_il[3], s_vc[2], s_vt;
  longint exp_r[2][3], act_r[2][3];
  longint gbuf[16];
  int     gptr;
  longint gsum, gprev;
  longint integ[2];

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc_all);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic longint sat(longint x);
    if (x > 32767) return 32767;
    if (x < -32768) return -32768;
    return x;
  endfunction

  task automatic check(string req, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, expv);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 16; i++) gbuf[i] = 0;
    gptr = 0; gsum = 0; gprev = 0; integ[0] = 0; integ[1] = 0;
  endtask

  task automatic model_step();
    longint num, den, mag, g, gbar, e, acc, gl, ge, vset;
    num = 0; den = 0;
    for (int i = 0; i < 3; i++) begin
      num += s_sync[i] * s_il[i];
      den += s_sync[i] * s_sync[i];
    end
    if (den == 0) g = gprev;
    else begin
      mag = ((num < 0 ? -num : num) << FB) / den;
      if (mag > 32767) mag = 32767;
      g = (num < 0) ? -mag : mag;
    end
    gprev = g;
    gsum = gsum + g - gbuf[gptr];
    gbuf[gptr] = g;
    gptr = (gptr + 1) % 16;
    gbar = gsum >>> WL;
    vset = s_vt >>> 1;
    for (int k = 0; k < 2; k++) begin
      e = vset - s_vc[k];
      acc = integ[k] + KI * e;
      if (acc > ILIM) acc = ILIM;
      if (acc < -ILIM) acc = -ILIM;
      integ[k] = acc;
      gl = sat((KP * e + acc) >>> SH);
      ge = sat(gbar + gl);
      for (int x = 0; x < 3; x++) exp_r[k][x] = sat(((ge * s_sync[x]) >>> FB) - s_il[x]);
    end
  endtask

  task automatic grab();
    act_r[0][0] = iref1_a; act_r[0][1] = iref1_b; act_r[0][2] = iref1_c;
    act_r[1][0] = iref2_a; act_r[1][1] = iref2_b; act_r[1][2] = iref2_c;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  // one sample through the block; stall = cycles of held back-pressure
  task automatic send(int stall, string req);
    int cyc;
    logic moved;
    longint held[2][3];
    @(negedge clk);
    sync_a = DW'(s_sync[0]); sync_b = DW'(s_sync[1]); sync_c = DW'(s_sync[2]);
    iload_a = DW'(s_il[0]); iload_b = DW'(s_il[1]); iload_c = DW'(s_il[2]);
    vcap_1 = DW'(s_vc[0]); vcap_2 = DW'(s_vc[1]); vlink_ref = DW'(s_vt);
    in_valid = 1'b1;
    check("R1 in_ready when idle", longint'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    cyc = 0;
    while (!out_valid && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    check("R2 latency", cyc, LAT);
    check("R1 in_ready low while result waits", longint'(in_ready), 0);
    model_step();
    grab();
    for (int k = 0; k < 2; k++)
      for (int x = 0; x < 3; x++) check(req, act_r[k][x], exp_r[k][x]);
    held = act_r;
    moved = 1'b0;
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      grab();
      if (act_r != held || !out_valid || in_ready) moved = 1'b1;
    end
    if (stall > 0) check("R3 hold under back-pressure", longint'(moved), 0);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R3 valid drops after handshake", longint'(out_valid), 0);
  endtask

  function automatic longint rnd(int lo, int hi);
    return longint'($urandom_range(hi - lo, 0)) + lo;
  endfunction

  initial begin
    int unsigned seed_v;
    logic eq;
    seed_v = $urandom(32'h1d2c3b4a);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    sync_a = '0; sync_b = '0; sync_c = '0;
    iload_a = '0; iload_b = '0; iload_c = '0;
    vcap_1 = '0; vcap_2 = '0; vlink_ref = '0;
    do_reset();

    // R10 reset state
    @(negedge clk);
    check("R10 out_valid", longint'(out_valid), 0);
    check("R10 in_ready", longint'(in_ready), 1);
    grab();
    for (int k = 0; k < 2; k++)
      for (int x = 0; x < 3; x++) check("R10 refs zero", act_r[k][x], 0);

    // R9 equal capacitor voltages give equal sets
    s_vt = 1600;
    for (int n = 0; n < 6; n++) begin
      for (int i = 0; i < 3; i++) begin s_sync[i] = rnd(-4096, 4096); s_il[i] = rnd(-6000, 6000); end
      s_vc[0] = rnd(600, 1000); s_vc[1] = s_vc[0];
      send(0, "R9 model");
      eq = 1'b1;
      for (int x = 0; x < 3; x++) if (act_r[0][x] != act_r[1][x]) eq = 1'b0;
      check("R9 sets equal", longint'(eq), 1);
    end

    // R5 zero synchronising inputs hold G
    s_sync[0] = 0; s_sync[1] = 0; s_sync[2] = 0;
    s_il[0] = 1234; s_il[1] = -777; s_il[2] = 55; s_vc[0] = 800; s_vc[1] = 790;
    send(1, "R5 zero divisor sample");
    s_sync[0] = 4096; s_sync[1] = -2048; s_sync[2] = -2048;
    s_il[0] = 3000; s_il[1] = -1000; s_il[2] = -2000;
    send(0, "R5 held G in window");

    // random stream: R4 R6 R7 R8 with random stalls
    for (int n = 0; n < 60; n++) begin
      for (int i = 0; i < 3; i++) begin s_sync[i] = rnd(-4200, 4200); s_il[i] = rnd(-12000, 12000); end
      if (n % 10 == 3) begin s_sync[0] = 32767; s_sync[1] = 0; s_sync[2] = 0; s_il[0] = -32768; end
      s_vc[0] = rnd(500, 1100); s_vc[1] = rnd(500, 1100);
      s_vt = (n % 7 == 0) ? rnd(-4000, 4000) : 1600;
      send(int'($urandom_range(3, 0)), "R4 R6 R7 R8 random");
    end

    // R6 window: constant conductance, window filling from zero
    do_reset();
    s_vt = 1600; s_vc[0] = 800; s_vc[1] = 800;
    for (int n = 0; n < 20; n++) begin
      s_sync[0] = 4096; s_sync[1] = 0; s_sync[2] = 0;
      s_il[0] = (n < 10) ? 2048 : -1024; s_il[1] = 0; s_il[2] = 0;
      send(0, "R6 window fill");
    end

    // R11 integrator limit
    do_reset();
    s_vt = 0; s_vc[0] = -32768; s_vc[1] = -32768;
    s_sync[0] = 4096; s_sync[1] = 0; s_sync[2] = 0;
    s_il[0] = 0; s_il[1] = 0; s_il[2] = 0;
    for (int n = 0; n < 40; n++) send(0, "R11 ramp");
    check("R11 settled set1", act_r[0][0], 18432);
    check("R11 settled set2", act_r[1][0], 18432);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule